// File: doc/BRIEF.md
# Dual-Channel DMA Programming Register Bank

This block holds the software-visible programming state for a pair of DMA channels and raises their completion interrupts. A simple memory-mapped port with separate read and write strobes reaches every register. Each register kind owns a fixed offset. The copy belonging to channel n sits n words above that offset, so the two channels' registers of one kind lie side by side.

The data-moving engine is not part of this block. It receives the transfer setup on per-channel outputs: the enable, the fetch request, the address modes, the burst and sample codes, the pack and abort bits, and the byte count, addresses, next pointer and priority. It reports back through strobes and levels: fetch acknowledge, active, transfer done and current descriptor pointer.

Each channel raises its own interrupt line when its completion status and its mask are both set. A combined line ORs the two channel lines, for systems that wire only one interrupt.

Top module: `dma2_regbank`

## Requirements
- R1: After reset every register reads zero and every control output, interrupt line and the read data bus are zero.
- R2: Register offsets follow a fixed map, and channel n's copy of each register is at offset + 4*n:
   - byte count 0x00, source address 0x10, destination address 0x20 and next-descriptor pointer 0x30 hold all 32 bits written.
   - priority 0x60 holds only its low 4 bits; the upper bits read zero.
   - Writing one channel's copy leaves the other channel's copy unchanged.
- R3: Control word at 0x40. The listed fields are stored and drive the channel outputs; all other bits read zero:
   - bit 12 enable
   - bits 3:2 source mode and bits 5:4 destination mode (0 increment, 2 hold)
   - bits 8:6 burst code
   - bits 24:22 sample-size code
   - bit 16 pack
   - bit 20 abort
- R4: Control bit 13 is the fetch request:
   - Writing 1 raises the channel's fetch request output, and bit 13 reads back 1.
   - A later write with bit 13 at 0 does not cancel the request.
   - The request clears on the clock edge where the engine's fetch acknowledge is high.
- R5: Control bit 14 reads back the engine's active level; software writes to bit 14 have no effect.
- R6: The current-descriptor register at 0x70 is read-only and reads the engine's current descriptor pointer for that channel.
- R7: Completion and the status register at 0xA0:
   - An engine done strobe sets status bit 0.
   - Writing 0 to that bit clears it; writing 1 has no effect.
   - The status bit sets whether or not the interrupt is masked.
- R8: A done strobe in the same cycle as a software clear leaves status bit 0 set.
- R9: A channel's interrupt line is high exactly when its status bit 0 and its mask bit 0 (register 0xA0 and register 0x80) are both set. The combined line is the OR of the two channel lines.
- R10: Unmapped offsets read zero and ignore writes. Unmapped means any of:
   - an offset that is not a register offset of the map
   - a non-word-aligned address
   - a channel index of 2 or more
- R11: Read data is registered: it appears on the bus the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| eng_fetch_ack | input | 2 | Per-channel fetch acknowledge |
| eng_active | input | 2 | Per-channel active level |
| eng_done | input | 2 | Per-channel completion strobe |
| eng_cur_desc | input | 64 | Per-channel current descriptor pointer |
| ch_enable | output | 2 | Channel enable |
| ch_fetch_req | output | 2 | Pending descriptor fetch request |
| ch_abort | output | 2 | Channel abort |
| ch_pack | output | 2 | Pack mode |
| ch_src_mode | output | 4 | Source address mode, 2 bits per channel |
| ch_dst_mode | output | 4 | Destination address mode, 2 bits per channel |
| ch_burst | output | 6 | Burst code, 3 bits per channel |
| ch_sample | output | 6 | Sample-size code, 3 bits per channel |
| ch_byte_cnt | output | 64 | Byte count per channel |
| ch_src_addr | output | 64 | Source address per channel |
| ch_dst_addr | output | 64 | Destination address per channel |
| ch_next_desc | output | 64 | Next-descriptor pointer per channel |
| ch_prio | output | 8 | Priority, 4 bits per channel |
| irq | output | 2 | Per-channel interrupt |
| irq_any | output | 1 | OR of the channel interrupts |

## Verification
The properties assume the engine behaves in a few ways:
- A fetch acknowledge arrives only while a request is pending.
- Done strobes are single-cycle.
- The read and write strobes are never asserted together.

The stimulus drives each strobe for exactly one cycle from a task. It pulses acknowledge only after it has seen the request high, and it never overlaps a read with a write. The one deliberate overlap is a done strobe landing on the same edge as a status clear, which the properties allow.

// File: rtl/dma2_pkg.sv
package dma2_pkg;

   typedef enum logic [3:0] {
      RS_NONE,
      RS_BCNT,
      RS_SRC,
      RS_DST,
      RS_NEXT,
      RS_CTRL,
      RS_PRIO,
      RS_CUR,
      RS_MASK,
      RS_STAT
   } reg_sel_t;

   localparam logic [7:0] OFS_BCNT = 8'h00;
   localparam logic [7:0] OFS_SRC  = 8'h10;
   localparam logic [7:0] OFS_DST  = 8'h20;
   localparam logic [7:0] OFS_NEXT = 8'h30;
   localparam logic [7:0] OFS_CTRL = 8'h40;
   localparam logic [7:0] OFS_PRIO = 8'h60;
   localparam logic [7:0] OFS_CUR  = 8'h70;
   localparam logic [7:0] OFS_MASK = 8'h80;
   localparam logic [7:0] OFS_STAT = 8'hA0;

   localparam int CB_SRC_LO  = 2;
   localparam int CB_DST_LO  = 4;
   localparam int CB_BST_LO  = 6;
   localparam int CB_EN      = 12;
   localparam int CB_FETCH   = 13;
   localparam int CB_ACT     = 14;
   localparam int CB_PACK    = 16;
   localparam int CB_ABORT   = 20;
   localparam int CB_SMP_LO  = 22;

   localparam logic [31:0] CTRL_STORE_MASK = 32'h01D1_11FC;

endpackage

// File: rtl/dma2_addr_decode.sv
module dma2_addr_decode
   import dma2_pkg::*;
#(
   parameter int AW  = 8,
   parameter int NCH = 2,
   localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [AW-1:0]  addr,
   output reg_sel_t       sel,
   output logic [CHB-1:0] idx,
   output logic           hit
);

   localparam logic [AW-1:0] CH_FIELD = AW'(((1 << CHB) - 1) << 2);

   logic [AW-1:0] base;

   always_comb begin
      base = addr & ~CH_FIELD;
      idx  = addr[2 +: CHB];
      sel  = RS_NONE;
      if (addr[1:0] == 2'b00 && int'(idx) < NCH) begin
         case (base)
            AW'(OFS_BCNT): sel = RS_BCNT;
            AW'(OFS_SRC):  sel = RS_SRC;
            AW'(OFS_DST):  sel = RS_DST;
            AW'(OFS_NEXT): sel = RS_NEXT;
            AW'(OFS_CTRL): sel = RS_CTRL;
            AW'(OFS_PRIO): sel = RS_PRIO;
            AW'(OFS_CUR):  sel = RS_CUR;
            AW'(OFS_MASK): sel = RS_MASK;
            AW'(OFS_STAT): sel = RS_STAT;
            default:       sel = RS_NONE;
         endcase
      end
      hit = (sel != RS_NONE);
   end

endmodule

// File: rtl/dma2_chan_regs.sv
module dma2_chan_regs
   import dma2_pkg::*;
#(
   parameter int DW     = 32,
   parameter int PRIO_W = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  reg_sel_t      sel,
   input  logic [DW-1:0] wdata,
   input  logic          fetch_ack,
   input  logic          active,
   input  logic          done,
   input  logic [DW-1:0] cur_desc,
   output logic [DW-1:0] rd_word,
   output logic          enable,
   output logic          fetch_req,
   output logic          abort,
   output logic          pack,
   output logic [1:0]    src_mode,
   output logic [1:0]    dst_mode,
   output logic [2:0]    burst,
   output logic [2:0]    sample,
   output logic [DW-1:0] byte_cnt,
   output logic [DW-1:0] src_addr,
   output logic [DW-1:0] dst_addr,
   output logic [DW-1:0] next_desc,
   output logic [PRIO_W-1:0] prio,
   output logic          stat_bit,
   output logic          mask_bit,
   output logic          irq
);

   localparam logic [DW-1:0] STORE_MASK = DW'(CTRL_STORE_MASK);

   logic [DW-1:0]     bcnt_q, src_q, dst_q, next_q, ctrl_q;
   logic [PRIO_W-1:0] prio_q;
   logic              fetch_q, mask_q, stat_q;
   logic              clr_req;

   assign clr_req = wr && (sel == RS_STAT) && !wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bcnt_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         next_q  <= '0;
         ctrl_q  <= '0;
         prio_q  <= '0;
         fetch_q <= 1'b0;
         mask_q  <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         if (wr) begin
            case (sel)
               RS_BCNT: bcnt_q <= wdata;
               RS_SRC:  src_q  <= wdata;
               RS_DST:  dst_q  <= wdata;
               RS_NEXT: next_q <= wdata;
               RS_CTRL: ctrl_q <= wdata & STORE_MASK;
               RS_PRIO: prio_q <= wdata[PRIO_W-1:0];
               RS_MASK: mask_q <= wdata[0];
               default: ;
            endcase
         end
         // a new request written on the same edge as an ack wins
         fetch_q <= (fetch_q && !fetch_ack) ||
                    (wr && sel == RS_CTRL && wdata[CB_FETCH]);
         // completion outranks a simultaneous clear
         stat_q  <= done || (stat_q && !clr_req);
      end
   end

   always_comb begin
      rd_word = '0;
      case (sel)
         RS_BCNT: rd_word = bcnt_q;
         RS_SRC:  rd_word = src_q;
         RS_DST:  rd_word = dst_q;
         RS_NEXT: rd_word = next_q;
         RS_CTRL: begin
            rd_word = ctrl_q;
            rd_word[CB_FETCH] = fetch_q;
            rd_word[CB_ACT]   = active;
         end
         RS_PRIO: rd_word = DW'(prio_q);
         RS_CUR:  rd_word = cur_desc;
         RS_MASK: rd_word = DW'(mask_q);
         RS_STAT: rd_word = DW'(stat_q);
         default: rd_word = '0;
      endcase
   end

   assign enable    = ctrl_q[CB_EN];
   assign fetch_req = fetch_q;
   assign abort     = ctrl_q[CB_ABORT];
   assign pack      = ctrl_q[CB_PACK];
   assign src_mode  = ctrl_q[CB_SRC_LO +: 2];
   assign dst_mode  = ctrl_q[CB_DST_LO +: 2];
   assign burst     = ctrl_q[CB_BST_LO +: 3];
   assign sample    = ctrl_q[CB_SMP_LO +: 3];
   assign byte_cnt  = bcnt_q;
   assign src_addr  = src_q;
   assign dst_addr  = dst_q;
   assign next_desc = next_q;
   assign prio      = prio_q;
   assign stat_bit  = stat_q;
   assign mask_bit  = mask_q;
   assign irq       = stat_q && mask_q;

endmodule

// File: rtl/dma2_read_port.sv
module dma2_read_port #(
   parameter int DW       = 32,
   parameter bit REG_READ = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd,
   input  logic [DW-1:0] word,
   output logic [DW-1:0] rdata
);

   generate
      if (REG_READ) begin : g_reg
         logic [DW-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)  rdata_q <= '0;
            else if (rd) rdata_q <= word;
         end
         assign rdata = rdata_q;
      end else begin : g_comb
         assign rdata = rd ? word : '0;
      end
   endgenerate

endmodule

// File: rtl/dma2_regbank.sv
module dma2_regbank
   import dma2_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 32,
   parameter int NCH      = 2,
   parameter int PRIO_W   = 4,
   parameter bit REG_READ = 1'b1,
   localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [AW-1:0]         bus_addr,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic [NCH-1:0]        eng_fetch_ack,
   input  logic [NCH-1:0]        eng_active,
   input  logic [NCH-1:0]        eng_done,
   input  logic [NCH*DW-1:0]     eng_cur_desc,
   output logic [NCH-1:0]        ch_enable,
   output logic [NCH-1:0]        ch_fetch_req,
   output logic [NCH-1:0]        ch_abort,
   output logic [NCH-1:0]        ch_pack,
   output logic [NCH*2-1:0]      ch_src_mode,
   output logic [NCH*2-1:0]      ch_dst_mode,
   output logic [NCH*3-1:0]      ch_burst,
   output logic [NCH*3-1:0]      ch_sample,
   output logic [NCH*DW-1:0]     ch_byte_cnt,
   output logic [NCH*DW-1:0]     ch_src_addr,
   output logic [NCH*DW-1:0]     ch_dst_addr,
   output logic [NCH*DW-1:0]     ch_next_desc,
   output logic [NCH*PRIO_W-1:0] ch_prio,
   output logic [NCH-1:0]        irq,
   output logic                  irq_any
);

   initial begin
      if (NCH < 2 || NCH > 4)
         $fatal(1, "NCH must be 2..4 so channel copies fit the 16-byte type spacing");
      if (AW < 8)
         $fatal(1, "AW must cover the full register map");
      if (DW != 32)
         $fatal(1, "DW must be 32 to hold the control fields and word stride");
      if (PRIO_W < 1 || PRIO_W > DW)
         $fatal(1, "PRIO_W out of range");
   end

   reg_sel_t       dec_sel;
   logic [CHB-1:0] dec_idx;
   logic           dec_hit;
   logic [DW-1:0]  chan_word [NCH];
   logic [NCH-1:0] st_bit;
   logic [NCH-1:0] mk_bit;
   logic [DW-1:0]  rd_mux;

   dma2_addr_decode #(.AW(AW), .NCH(NCH)) u_dec (
      .addr (bus_addr),
      .sel  (dec_sel),
      .idx  (dec_idx),
      .hit  (dec_hit)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic wr_c;
         assign wr_c = bus_wr && dec_hit && (dec_idx == CHB'(c));

         dma2_chan_regs #(.DW(DW), .PRIO_W(PRIO_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_c),
            .sel       (dec_sel),
            .wdata     (bus_wdata),
            .fetch_ack (eng_fetch_ack[c]),
            .active    (eng_active[c]),
            .done      (eng_done[c]),
            .cur_desc  (eng_cur_desc[c*DW +: DW]),
            .rd_word   (chan_word[c]),
            .enable    (ch_enable[c]),
            .fetch_req (ch_fetch_req[c]),
            .abort     (ch_abort[c]),
            .pack      (ch_pack[c]),
            .src_mode  (ch_src_mode[c*2 +: 2]),
            .dst_mode  (ch_dst_mode[c*2 +: 2]),
            .burst     (ch_burst[c*3 +: 3]),
            .sample    (ch_sample[c*3 +: 3]),
            .byte_cnt  (ch_byte_cnt[c*DW +: DW]),
            .src_addr  (ch_src_addr[c*DW +: DW]),
            .dst_addr  (ch_dst_addr[c*DW +: DW]),
            .next_desc (ch_next_desc[c*DW +: DW]),
            .prio      (ch_prio[c*PRIO_W +: PRIO_W]),
            .stat_bit  (st_bit[c]),
            .mask_bit  (mk_bit[c]),
            .irq       (irq[c])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NCH; c++) begin
         if (dec_hit && dec_idx == CHB'(c)) rd_mux = chan_word[c];
      end
   end

   dma2_read_port #(.DW(DW), .REG_READ(REG_READ)) u_rdp (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (bus_rd),
      .word  (rd_mux),
      .rdata (bus_rdata)
   );

   assign irq_any = |irq;

endmodule

// File: rtl/dma2_regbank_chk.sv
module dma2_regbank_chk #(
   parameter int DW       = 32,
   parameter int NCH      = 2,
   parameter bit REG_READ = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_wr,
   input logic           bus_rd,
   input logic [DW-1:0]  bus_rdata,
   input logic           dec_hit,
   input logic [NCH-1:0] eng_fetch_ack,
   input logic [NCH-1:0] eng_done,
   input logic [NCH-1:0] ch_fetch_req,
   input logic [NCH-1:0] st_bit,
   input logic           irq_any
);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_c
         assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            eng_done[c] |=> st_bit[c]);

         assert_stat_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_wr && !eng_done[c]) |=> $stable(st_bit[c]));

         // R8: a set bit never drops while a done strobe is present
         assert_done_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (st_bit[c] && eng_done[c]) |=> st_bit[c]);

         assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_fetch_req[c] && !eng_fetch_ack[c]) |=> ch_fetch_req[c]);

         assert_fetch_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_fetch_req[c]) |-> $past(bus_wr));
      end
   endgenerate

   assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_any) |-> ($past(|eng_done) || $past(bus_wr)));

   generate
      if (REG_READ) begin : g_rd
         assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !dec_hit) |=> (bus_rdata == '0));
      end
   endgenerate

endmodule

bind dma2_regbank dma2_regbank_chk #(.DW(DW), .NCH(NCH), .REG_READ(REG_READ)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_wr        (bus_wr),
   .bus_rd        (bus_rd),
   .bus_rdata     (bus_rdata),
   .dec_hit       (dec_hit),
   .eng_fetch_ack (eng_fetch_ack),
   .eng_done      (eng_done),
   .ch_fetch_req  (ch_fetch_req),
   .st_bit        (st_bit),
   .irq_any       (irq_any)
);

// File: tb/tb_dma2_regbank.sv
module tb_dma2_regbank;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam int NCH = 2;
   localparam int PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NCH-1:0] eng_fetch_ack = '0, eng_active = '0, eng_done = '0;
   logic [NCH*DW-1:0] eng_cur_desc = '0;
   logic [NCH-1:0] ch_enable, ch_fetch_req, ch_abort, ch_pack, irq;
   logic [NCH*2-1:0] ch_src_mode, ch_dst_mode;
   logic [NCH*3-1:0] ch_burst, ch_sample;
   logic [NCH*DW-1:0] ch_byte_cnt, ch_src_addr, ch_dst_addr, ch_next_desc;
   logic [NCH*PW-1:0] ch_prio;
   logic irq_any;

   always #2 clk = ~clk;

   dma2_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_fetch_ack(eng_fetch_ack), .eng_active(eng_active), .eng_done(eng_done),
      .eng_cur_desc(eng_cur_desc), .ch_enable(ch_enable), .ch_fetch_req(ch_fetch_req),
      .ch_abort(ch_abort), .ch_pack(ch_pack), .ch_src_mode(ch_src_mode),
      .ch_dst_mode(ch_dst_mode), .ch_burst(ch_burst), .ch_sample(ch_sample),
      .ch_byte_cnt(ch_byte_cnt), .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr),
      .ch_next_desc(ch_next_desc), .ch_prio(ch_prio), .irq(irq), .irq_any(irq_any)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [DW-1:0] exp_q [$];
   string         tag_q [$];
   logic          rd_fire = 1'b0;

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: one read result due at each negedge after a read edge
   always @(posedge clk) rd_fire <= bus_rd;
   always @(negedge clk) begin
      if (rd_fire) begin
         if (exp_q.size() == 0) begin
            chk("R11 unexpected read", bus_rdata, 32'hDEAD_0000);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_done(input int c);
      @(negedge clk); eng_done[c] = 1'b1;
      @(negedge clk); eng_done[c] = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 enable", 32'(ch_enable), 0);
      chk("R1 fetch", 32'(ch_fetch_req), 0);
      chk("R1 irq", 32'({irq_any, irq}), 0);
      chk("R1 rdata", bus_rdata, 0);
      rst_n = 1'b1;
      rd(8'h40, 0, "R1 ctrl0");
      rd(8'hA4, 0, "R1 stat1");
      rd(8'h04, 0, "R1 bcnt1");

      // R2 plain registers and channel interleave
      wr(8'h00, 32'h1234_5678);
      wr(8'h04, 32'h9ABC_DEF0);
      wr(8'h10, 32'h0000_1000);
      wr(8'h24, 32'h2000_0040);
      wr(8'h30, 32'h8000_0040);
      wr(8'h64, 32'hFFFF_FFFF);
      rd(8'h00, 32'h1234_5678, "R2 bcnt0 after bcnt1 write");
      rd(8'h04, 32'h9ABC_DEF0, "R2 bcnt1");
      rd(8'h10, 32'h0000_1000, "R2 src0");
      rd(8'h24, 32'h2000_0040, "R2 dst1");
      rd(8'h20, 0, "R2 dst0 untouched");
      rd(8'h64, 32'h0000_000F, "R2 prio1 width");
      chk("R2 byte_cnt port ch1", ch_byte_cnt[63:32], 32'h9ABC_DEF0);
      chk("R2 next_desc port ch0", ch_next_desc[31:0], 32'h8000_0040);
      chk("R2 prio port ch1", 32'(ch_prio[7:4]), 32'hF);

      // R3 control fields
      wr(8'h40, 32'hFFFF_DFFF);
      rd(8'h40, 32'h01D1_11FC, "R3 ctrl0 unused bits zero");
      chk("R3 all-ones fields", {ch_enable[0], ch_abort[0], ch_pack[0], ch_src_mode[1:0],
          ch_dst_mode[1:0], ch_burst[2:0], ch_sample[2:0], 19'd0},
          {1'b1, 1'b1, 1'b1, 2'd3, 2'd3, 3'd7, 3'd7, 19'd0});
      wr(8'h40, 32'h00C0_11A0);
      chk("R3 pattern fields", {ch_enable[0], ch_abort[0], ch_pack[0], ch_src_mode[1:0],
          ch_dst_mode[1:0], ch_burst[2:0], ch_sample[2:0], 19'd0},
          {1'b1, 1'b0, 1'b0, 2'd0, 2'd2, 3'd6, 3'd3, 19'd0});
      chk("R3 ch1 outputs idle", 32'({ch_enable[1], ch_burst[5:3], ch_dst_mode[3:2]}), 0);

      // R4 fetch request
      wr(8'h44, 32'h0000_2000);
      chk("R4 fetch raised", 32'(ch_fetch_req[1]), 1);
      rd(8'h44, 32'h0000_2000, "R4 fetch reads 1");
      wr(8'h44, 32'h0000_1000);
      chk("R4 write 0 no cancel", 32'(ch_fetch_req[1]), 1);
      rd(8'h44, 32'h0000_3000, "R4 still pending");
      @(negedge clk); eng_fetch_ack[1] = 1'b1;
      @(negedge clk); eng_fetch_ack[1] = 1'b0;
      chk("R4 cleared by ack", 32'(ch_fetch_req[1]), 0);
      rd(8'h44, 32'h0000_1000, "R4 reads 0 after ack");

      // R5 active flag
      eng_active[0] = 1'b1;
      rd(8'h40, 32'h00C0_51A0, "R5 active reads 1");
      wr(8'h44, 32'h0000_4000);
      rd(8'h44, 0, "R5 write to active ignored");
      eng_active[0] = 1'b0;

      // R6 current descriptor
      eng_cur_desc = {32'hCAFE_0010, 32'h00BE_EF20};
      wr(8'h70, 32'hFFFF_FFFF);
      rd(8'h70, 32'h00BE_EF20, "R6 cur0 read-only");
      rd(8'h74, 32'hCAFE_0010, "R6 cur1");

      // R7 / R9 completion and interrupt
      wr(8'h80, 32'hFFFF_FFFF);
      rd(8'h80, 1, "R9 mask0 one bit");
      pulse_done(0);
      chk("R9 irq0 set", 32'({irq_any, irq}), 32'b101);
      rd(8'hA0, 1, "R7 stat0 set");
      wr(8'hA0, 32'h1);
      rd(8'hA0, 1, "R7 write 1 no effect");
      wr(8'hA0, 32'h0);
      chk("R7 clear drops irq", 32'({irq_any, irq}), 0);
      rd(8'hA0, 0, "R7 stat0 cleared");
      wr(8'h80, 32'h0);
      pulse_done(0);
      chk("R9 masked no irq", 32'({irq_any, irq}), 0);
      rd(8'hA0, 1, "R7 masked still sets");
      wr(8'hA0, 32'h0);
      wr(8'h84, 32'h1);
      pulse_done(1);
      chk("R9 irq1 and any", 32'({irq_any, irq}), 32'b110);

      // R8 done on the same edge as a clear
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'hA4; bus_wdata = 0; eng_done[1] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; eng_done[1] = 1'b0;
      chk("R8 irq1 held", 32'(irq[1]), 1);
      rd(8'hA4, 1, "R8 stat1 kept");
      wr(8'hA4, 32'h0);
      rd(8'hA4, 0, "R8 later clear works");

      // R10 unmapped offsets
      wr(8'h50, 32'hFFFF_FFFF);
      wr(8'h48, 32'hFFFF_FFFF);
      wr(8'h41, 32'hFFFF_FFFF);
      wr(8'hC0, 32'hFFFF_FFFF);
      wr(8'h01, 32'hFFFF_FFFF);
      rd(8'h50, 0, "R10 gap read");
      rd(8'h48, 0, "R10 channel 2 read");
      rd(8'hC0, 0, "R10 beyond map");
      rd(8'h41, 0, "R10 misaligned read");
      rd(8'h40, 32'h00C0_11A0, "R10 ctrl0 untouched");
      rd(8'h00, 32'h1234_5678, "R10 bcnt0 untouched");

      // R11 latency: before the read edge the bus still holds the old result
      rd(8'hA0, 0, "R11 prior read");
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 8'h04;
      exp_q.push_back(32'h9ABC_DEF0); tag_q.push_back("R11 data one cycle later");
      chk("R11 not yet updated", bus_rdata, 0);
      @(negedge clk);
      bus_rd = 1'b0;

      repeat (3) @(negedge clk);
      chk("R11 scoreboard drained", 32'(exp_q.size()), 0);
      finish_run();
   end

endmodule